// File: doc/BRIEF.md
# Cut-Through Transmit Cell Buffer

This block sits between a frame source and a MAC transmitter. Outgoing frame bytes come in one byte per accepted beat, with a flag on the final byte of each frame. They are held in a byte buffer that is counted in 64-byte cells. The transmitter is not let in as soon as the first byte arrives. It is also not made to wait for the whole frame. The block releases a frame once a programmable number of complete cells of that frame is held. A frame smaller than that number of cells is released as soon as its final byte is stored.

A small register input sets the cell threshold. The stored value is forced into the range 2 to 24, and it comes out of reset at 24. On the read side, frames go out one at a time, with a start flag on the first byte and a last flag on the final byte. Once a frame has started, its bytes follow back to back. A gap appears only when the source has not yet delivered the next byte. A decision to start the next frame is made only after the previous frame's final byte has been taken.

Top module: `tx_cell_fifo`

## Requirements
- R1: After reset, `rd_valid` and `rd_start` are 0, `wr_ready` is 1, and the cell threshold is 24.
- R2: A cycle with `thr_we` high loads `thr_wdata` into the threshold. A value below 2 is stored as 2, and a value above 24 is stored as 24.
- R3: A frame whose final byte has not been stored starts when the number of complete 64-byte cells it holds is at least the threshold. `rd_valid` rises one clock after the write that reaches that count.
- R4: A frame with fewer bytes than threshold × 64 starts once its final byte is stored, so a partly filled last cell counts. `rd_valid` rises one clock after that write.
- R5: `rd_start` is 1 only with the first byte of each frame. `rd_last` is 1 exactly with the byte that was written with `wr_last` = 1.
- R6: Bytes leave in the order they were written, with the values they were written with.
- R7: `rd_valid` is never 1 while the buffer is empty. A started frame whose source is slower than the reader pauses, then resumes with the next byte, and `rd_start` is not raised again.
- R8: After the final byte of a frame is read, `rd_valid` is 0 for at least one cycle. A following frame that is already fully stored then starts without regard to the threshold.
- R9: `wr_ready` is 0 while 2048 bytes are held. A write offered while `wr_ready` is 0 is dropped and never appears on the read side.
- R10: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid`, `rd_data` and `rd_last` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 5 | Threshold value in cells, clamped to 2..24 when stored |
| wr_valid | input | 1 | Source offers a byte |
| wr_ready | output | 1 | Buffer can take a byte (not full) |
| wr_data | input | 8 | Frame byte from the source |
| wr_last | input | 1 | Byte is the final byte of its frame |
| rd_valid | output | 1 | Byte available to the transmitter |
| rd_ready | input | 1 | Transmitter takes the byte this cycle |
| rd_data | output | 8 | Frame byte to the transmitter |
| rd_start | output | 1 | Byte is the first of its frame |
| rd_last | output | 1 | Byte is the final byte of its frame |

## Verification
The embedded properties assume three things about the inputs. The source writes only while `wr_ready` is high. The reader uses a plain valid/ready handshake. Reset is held low before the first clock edge. The bench drives the source only at falling edges and checks `wr_ready` before it counts a byte as stored. One deliberate write into a full buffer checks that such a write is dropped. The bench takes bytes only through `rd_ready`, and it holds `rd_ready` low while it looks for the start point. The threshold values it programs include values below 2, exactly 2, and values above 24, so the clamp is exercised without any other input leaving its legal use.

// File: rtl/tcf_pkg.sv
// Package: constants and state type shared by the cut-through transmit buffer.
// Assumes: threshold limits are fixed by the start rule, not by the instance.
package tcf_pkg;
    localparam int THR_MIN   = 2;
    localparam int THR_MAX   = 24;
    localparam int THR_RESET = 24;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;
endpackage

// File: rtl/tcf_thresh_reg.sv
// Module: holds the start threshold in cells and clamps each written value
// into the legal range, so downstream logic never sees an unusable value.
// Assumes: THR_W wide enough to hold THR_MAX.
module tcf_thresh_reg
    import tcf_pkg::*;
#(
    parameter int THR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [THR_W-1:0] wdata,
    output logic [THR_W-1:0] thr_q
);
    localparam logic [THR_W-1:0] LO  = THR_W'(THR_MIN);
    localparam logic [THR_W-1:0] HI  = THR_W'(THR_MAX);
    localparam logic [THR_W-1:0] RST = THR_W'(THR_RESET);

    logic [THR_W-1:0] clamped;

    // Clamp the incoming value into LO..HI.
    always_comb begin
        if (wdata < LO)      clamped = LO;
        else if (wdata > HI) clamped = HI;
        else                 clamped = wdata;
    end

    // Threshold register: reset value, load on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  thr_q <= RST;
        else if (we) thr_q <= clamped;
    end

    p_thr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_q >= LO) && (thr_q <= HI))
        else $error("threshold left legal range");
endmodule

// File: rtl/tcf_store.sv
// Module: circular byte buffer with a per-byte last flag and an occupancy count.
// Read data is combinational from the read pointer (first-word fall-through).
// Assumes: push only when not full and pop only when not empty (checked below).
module tcf_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2048,
    parameter int AW     = $clog2(DEPTH),
    parameter int CW     = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              push_last,
    input  logic              pop,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic [CW-1:0]     count,
    output logic              full,
    output logic              empty
);
    localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

    logic [DATA_W:0] mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;

    assign full     = (count == CNT_MAX);
    assign empty    = (count == '0);
    assign out_data = mem[rd_ptr][DATA_W-1:0];
    assign out_last = mem[rd_ptr][DATA_W];

    // Storage write: capture byte and its last flag.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= {push_last, push_data};
    end

    // Pointer advance with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_MAX) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_MAX) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Occupancy in bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)            count <= '0;
        else if (push && !pop) count <= count + 1'b1;
        else if (pop && !push) count <= count - 1'b1;
    end

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full)
        else $error("push into full buffer");

    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty)
        else $error("pop from empty buffer");
endmodule

// File: rtl/tcf_start_ctrl.sv
// Module: frame tracking and the start decision. Counts complete frames held,
// decides when the head frame may go, and walks one frame at a time.
// Assumes: occupancy reflects only the head frame while idle, since the
// previous frame has been fully read before the idle state is entered.
module tcf_start_ctrl
    import tcf_pkg::*;
#(
    parameter int CW        = 12,
    parameter int CELL_LOG2 = 6,
    parameter int THR_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    count,
    input  logic             empty,
    input  logic [THR_W-1:0] thr,
    input  logic             push_eof,
    input  logic             pop,
    input  logic             pop_eof,
    output logic             rd_valid,
    output logic             rd_first
);
    tx_state_e     state;
    logic          first_q;
    logic [CW-1:0] frames;
    logic [CW-1:0] full_cells;
    logic          start_ok;

    assign full_cells = count >> CELL_LOG2;
    assign start_ok   = (frames != '0) || (full_cells >= CW'(thr));
    assign rd_valid   = (state == TX_SEND) && !empty;
    assign rd_first   = rd_valid && first_q;

    // Complete-frame counter: up on stored final byte, down on read final byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                   frames <= '0;
        else if (push_eof && !pop_eof) frames <= frames + 1'b1;
        else if (pop_eof && !push_eof) frames <= frames - 1'b1;
    end

    // Frame walk: idle until start rule holds, send until final byte read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            first_q <= 1'b0;
        end else begin
            case (state)
                TX_IDLE: if (start_ok) begin
                    state   <= TX_SEND;
                    first_q <= 1'b1;
                end
                TX_SEND: begin
                    if (pop)     first_q <= 1'b0;
                    if (pop_eof) state   <= TX_IDLE;
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    p_start_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE) && (frames == '0) && ((count >> CELL_LOG2) < CW'(thr))
        |=> (state == TX_IDLE))
        else $error("frame started below threshold");

    p_frames_le_bytes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frames <= count)
        else $error("more frames than bytes");
endmodule

// File: rtl/tx_cell_fifo.sv
// Module: cut-through transmit buffer top. Joins threshold register, byte
// store and start control; handshakes are plain valid/ready.
// Assumes: DEPTH_CELLS >= 24 so the largest threshold can always be reached.
module tx_cell_fifo
    import tcf_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CELL_BYTES  = 64,
    parameter int DEPTH_CELLS = 32,
    parameter int THR_W       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              thr_we,
    input  logic [THR_W-1:0]  thr_wdata,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_start,
    output logic              rd_last
);
    localparam int DEPTH     = CELL_BYTES * DEPTH_CELLS;
    localparam int AW        = $clog2(DEPTH);
    localparam int CW        = AW + 1;
    localparam int CELL_LOG2 = $clog2(CELL_BYTES);

    logic [THR_W-1:0] thr;
    logic [CW-1:0]    count;
    logic             full;
    logic             empty;
    logic             push;
    logic             pop;

    assign wr_ready = !full;
    assign push     = wr_valid && wr_ready;
    assign pop      = rd_valid && rd_ready;

    tcf_thresh_reg #(.THR_W(THR_W)) u_thr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (thr_we),
        .wdata (thr_wdata),
        .thr_q (thr)
    );

    tcf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (wr_data),
        .push_last (wr_last),
        .pop       (pop),
        .out_data  (rd_data),
        .out_last  (rd_last),
        .count     (count),
        .full      (full),
        .empty     (empty)
    );

    tcf_start_ctrl #(.CW(CW), .CELL_LOG2(CELL_LOG2), .THR_W(THR_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (count),
        .empty    (empty),
        .thr      (thr),
        .push_eof (push && wr_last),
        .pop      (pop),
        .pop_eof  (pop && rd_last),
        .rd_valid (rd_valid),
        .rd_first (rd_start)
    );

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_last))
        else $error("read side changed while stalled");

    p_gap_after_eof_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_ready && rd_last |=> !rd_valid)
        else $error("no idle cycle after final byte");

    p_start_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |-> rd_valid)
        else $error("start flag without valid");
endmodule

// File: tb/tx_cell_fifo_bench.sv
`timescale 1ns/1ps
module tx_cell_fifo_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       thr_we = 1'b0;
    logic [4:0] thr_wdata = '0;
    logic       wr_valid = 1'b0;
    logic       wr_ready;
    logic [7:0] wr_data = '0;
    logic       wr_last = 1'b0;
    logic       rd_valid;
    logic       rd_ready = 1'b0;
    logic [7:0] rd_data;
    logic       rd_start;
    logic       rd_last;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    tx_cell_fifo u_tx_cell_fifo (
        .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .thr_wdata(thr_wdata),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .rd_start(rd_start), .rd_last(rd_last)
    );

    // Vector table: frame length, threshold to program, program flag, expected
    // bytes stored when rd_valid first rises = min(len, clamp(thr)*64).
    localparam int NV = 8;
    localparam int V_LEN [NV] = '{2000, 10, 130, 200, 300, 1700, 128, 64};
    localparam int V_THR [NV] = '{0,    5,  3,   3,   0,   31,   2,   1};
    localparam int V_PRG [NV] = '{0,    1,  1,   1,   1,   1,    1,   1};
    localparam int V_EXP [NV] = '{1536, 10, 130, 192, 128, 1536, 128, 64};
    localparam string V_REQ [NV] = '{"R1", "R4", "R4", "R3", "R2", "R2", "R3", "R2"};

    function automatic logic [7:0] pat(int v, int i);
        return 8'(v * 37 + i * 5 + 1);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic program_thr(int val);
        thr_we = 1'b1; thr_wdata = 5'(val);
        @(posedge clk); @(negedge clk);
        thr_we = 1'b0;
    endtask

    // One byte every two cycles; report the stored count when rd_valid first rises.
    task automatic write_slow(int v, int len, output int seen_at, output int start_ok);
        seen_at = -1; start_ok = 0;
        for (int i = 0; i < len; i++) begin
            wr_valid = 1'b1; wr_data = pat(v, i); wr_last = (i == len - 1);
            @(posedge clk); @(negedge clk);
            wr_valid = 1'b0; wr_last = 1'b0;
            @(posedge clk); @(negedge clk);
            if (seen_at < 0 && rd_valid) begin
                seen_at = i + 1; start_ok = rd_start;
            end
        end
    endtask

    // Back-to-back writes of a frame, final flag on the last byte if eof.
    task automatic write_burst(int v, int len, bit eof);
        for (int i = 0; i < len; i++) begin
            wr_valid = 1'b1; wr_data = pat(v, i); wr_last = eof && (i == len - 1);
            @(posedge clk); @(negedge clk);
        end
        wr_valid = 1'b0; wr_last = 1'b0;
    endtask

    // Drain one frame with rd_ready held high and check its contents.
    task automatic drain(int v, int len);
        int bad_d = 0, bad_s = 0, bad_l = 0, bad_v = 0;
        rd_ready = 1'b1;
        for (int j = 0; j < len; j++) begin
            if (!rd_valid) bad_v++;
            if (rd_data != pat(v, j)) bad_d++;
            if (rd_start != (j == 0)) bad_s++;
            if (rd_last != (j == len - 1)) bad_l++;
            @(posedge clk); @(negedge clk);
        end
        rd_ready = 1'b0;
        chk(bad_v == 0, "R7", "valid gaps in stored frame", bad_v, 0);
        chk(bad_d == 0, "R6", "data mismatches", bad_d, 0);
        chk(bad_s == 0, "R5", "start flag errors", bad_s, 0);
        chk(bad_l == 0, "R5", "last flag errors", bad_l, 0);
        chk(!rd_valid, "R8", "valid after final byte", rd_valid, 0);
    endtask

    task automatic run_all();
        int seen, sflag;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(rd_valid == 0, "R1", "rd_valid after reset", rd_valid, 0);
        chk(rd_start == 0, "R1", "rd_start after reset", rd_start, 0);
        chk(wr_ready == 1, "R1", "wr_ready after reset", wr_ready, 1);

        // Table walk: start point, held output, then full drain.
        for (int v = 0; v < NV; v++) begin
            if (V_PRG[v] != 0) program_thr(V_THR[v]);
            write_slow(v, V_LEN[v], seen, sflag);
            chk(seen == V_EXP[v], V_REQ[v], "bytes stored at start", seen, V_EXP[v]);
            chk(sflag == 1, "R5", "start flag on first byte", sflag, 1);
            chk(rd_valid && rd_data == pat(v, 0), "R10", "held first byte",
                rd_data, pat(v, 0));
            drain(v, V_LEN[v]);
        end

        // R8: second frame fully stored starts at once despite threshold 24.
        program_thr(24);
        write_burst(11, 5, 1'b1);
        write_burst(12, 7, 1'b1);
        @(posedge clk); @(negedge clk);
        drain(11, 5);
        @(posedge clk); @(negedge clk);
        chk(rd_valid && rd_start, "R8", "stored next frame starts", rd_valid, 1);
        drain(12, 7);

        // R7: slow source, fast reader, frame pauses and resumes.
        program_thr(2);
        rd_ready = 1'b1;
        begin
            int nread = 0, bad = 0, gap = 0;
            fork
                begin
                    for (int i = 0; i < 200; i++) begin
                        wr_valid = 1'b1; wr_data = pat(13, i); wr_last = (i == 199);
                        @(posedge clk); @(negedge clk);
                        wr_valid = 1'b0; wr_last = 1'b0;
                        repeat (2) begin @(posedge clk); @(negedge clk); end
                    end
                end
                begin
                    for (int c = 0; c < 1500; c++) begin
                        if (rd_valid) begin
                            if (rd_data != pat(13, nread)) bad++;
                            if (rd_start != (nread == 0)) bad++;
                            if (rd_last != (nread == 199)) bad++;
                            nread++;
                        end else if (nread > 0 && nread < 200) begin
                            gap = 1;
                        end
                        @(posedge clk); @(negedge clk);
                        if (nread == 200) break;
                    end
                end
            join
            rd_ready = 1'b0;
            chk(nread == 200, "R7", "bytes read from paced frame", nread, 200);
            chk(bad == 0, "R7", "paced frame errors", bad, 0);
            chk(gap == 1, "R7", "pause seen mid-frame", gap, 1);
        end

        // R9: fill all 2048 bytes, offer a dropped write, drain, finish frame.
        program_thr(24);
        write_burst(14, 2048, 1'b0);
        chk(wr_ready == 0, "R9", "wr_ready when full", wr_ready, 0);
        wr_valid = 1'b1; wr_data = 8'hAA; wr_last = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_valid = 1'b0; wr_last = 1'b0;
        begin
            int bad = 0, bl = 0;
            rd_ready = 1'b1;
            for (int j = 0; j < 2048; j++) begin
                if (!rd_valid || rd_data != pat(14, j)) bad++;
                if (rd_last) bl++;
                @(posedge clk); @(negedge clk);
            end
            chk(bad == 0, "R6", "full buffer readout", bad, 0);
            chk(bl == 0, "R9", "dropped write produced a last flag", bl, 0);
        end
        chk(rd_valid == 0, "R7", "valid while empty mid-frame", rd_valid, 0);
        wr_valid = 1'b1; wr_data = 8'h55; wr_last = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_valid = 1'b0; wr_last = 1'b0;
        chk(rd_valid && rd_data == 8'h55, "R9", "byte after dropped write", rd_data, 8'h55);
        chk(rd_last == 1 && rd_start == 0, "R5", "final byte flags", {rd_last, rd_start}, 2);
        @(posedge clk); @(negedge clk);
        rd_ready = 1'b0;
        chk(rd_valid == 0, "R8", "idle after final byte", rd_valid, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL R1 watchdog actual=timeout expected=finish");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule